// File: doc/BRIEF.md
# Pin-Based Interrupt Dispatcher

This block watches a bank of interrupt request lines, one per pin, and keeps a pending bit for each in a request register. Every pin has a 64-bit redirection entry, supplied from a register file outside the block. The entry sets how the pin triggers, whether it is masked, and what the outgoing delivery message carries. The dispatcher scans the pending pins from the lowest number to the highest and sends one message per serviced pin over a valid/ready stream towards the processor-side interrupt controllers.

A pin set to edge mode latches a request on a rising edge of its line. That request is dropped once its message has been accepted. A pin set to level mode mirrors its line, so the bit stays pending after delivery and clears only when the line goes low. A scan pass starts only when some request line rises or some entry is rewritten. A level pin that stays high is therefore not sent again and again.

Back-pressure: a message, once presented, holds every field unchanged until `msg_ready` is seen high at a clock edge with `msg_valid` high. Only one message is outstanding at any time. The pass moves on to the next pending pin only after that acceptance.

Top module: `irq_dispatch_top`

## Requirements
- R1: Reset clears every pending bit and the sampled line history, and `msg_valid` is low. A line held high through reset is therefore seen as a fresh rising edge at the first clock after reset.
- R2: On an edge pin (entry bit 15 = 0), a rising line sets the pending bit. A line that rises before clock edge E0 gives `msg_valid` high after E1 when no message is outstanding. A later fall of the line does not clear the request.
- R3: The pending bit of an edge pin clears when its message is accepted, so a later rewrite of its entry produces no message.
- R4: On a level pin (entry bit 15 = 1), a high line sets the pending bit, and the bit stays set after delivery. A rewrite of the entry while the line is still high produces the message again.
- R5: On a level pin, a low line clears the pending bit, so a rewrite after the line falls produces no message.
- R6: A pin whose entry bit 16 is 1 is skipped and keeps its pending bit. Rewriting the entry with bit 16 cleared then delivers it.
- R7: Pending pins found in the same pass are sent in ascending pin order, and `msg_pin` names the pin.
- R8: Message fields come from the entry as follows: vector from bits 7:0, delivery mode from bits 10:8, destination mode from bit 11, polarity from bit 13, trigger mode from bit 15, and destination from bits 63:56.
- R9: When the delivery mode is 7, the message vector is 0xFF regardless of entry bits 7:0.
- R10: While `msg_valid` is high and `msg_ready` is low, the message and its fields stay stable. After acceptance, `msg_valid` is low in the next cycle.
- R11: Service runs only after a request line rises or an entry is rewritten. A level pin held high is not sent again without one of these events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | NUM_PINS | Interrupt request lines, sampled on the clock |
| entry_flat | input | NUM_PINS*64 | Redirection entries, pin i in bits [64*i+63:64*i] |
| entry_wr | input | NUM_PINS | One-cycle strobe per pin marking an entry rewrite |
| msg_valid | output | 1 | Delivery message present |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_pin | output | PIN_W | Pin that the message serves |
| msg_dest | output | 8 | Destination |
| msg_dest_mode | output | 1 | Destination mode |
| msg_dlv_mode | output | 3 | Delivery mode |
| msg_vector | output | 8 | Vector (0xFF for delivery mode 7) |
| msg_polarity | output | 1 | Polarity |
| msg_trigger | output | 1 | Trigger mode, 1 = level |

## Verification
The hardest state to reach is a pin that holds a pending bit but has no scan to serve it: a masked edge request whose line has already fallen, or a level pin that stays high after its message went out. The stimulus reaches both. It pulses a line while its entry is masked, or holds a level line high past acceptance. It then waits some idle cycles with no trigger and uses an entry rewrite alone to start a pass, which shows whether the bit survived. A line held high through reset and three lines that rise in the same cycle cover history clearing and the scan order.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

  localparam int ENTRY_W    = 64;
  localparam logic [2:0] DLV_EXTINT = 3'd7;

  typedef struct packed {
    logic [7:0] dest;
    logic       dest_mode;
    logic [2:0] dlv;
    logic [7:0] vector;
    logic       polarity;
    logic       level;
  } irqd_msg_t;

  function automatic irqd_msg_t decode_entry(input logic [ENTRY_W-1:0] e);
    irqd_msg_t m;
    m.dest      = e[63:56];
    m.dest_mode = e[11];
    m.dlv       = e[10:8];
    m.vector    = (e[10:8] == DLV_EXTINT) ? 8'hFF : e[7:0];
    m.polarity  = e[13];
    m.level     = e[15];
    return m;
  endfunction

endpackage

// File: rtl/irqd_capture.sv
module irqd_capture #(
  parameter int N = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] level_cfg,
  input  logic [N-1:0] clr_edge,
  output logic [N-1:0] pend,
  output logic [N-1:0] rise
);

  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= irq_in;
  end

  assign rise = irq_in & ~prev_q;

  for (genvar i = 0; i < N; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            pend[i] <= 1'b0;
      else if (level_cfg[i]) pend[i] <= irq_in[i];
      else if (rise[i])      pend[i] <= 1'b1;
      else if (clr_edge[i])  pend[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/irqd_pick.sv
module irqd_pick #(
  parameter int N     = 24,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx,
  output logic [N-1:0]     upto
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_upto
    assign upto[i] = found && (i <= int'(idx));
  end

endmodule

// File: rtl/irqd_sequencer.sv
module irqd_sequencer
  import irqd_pkg::*;
#(
  parameter int N     = 24,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             cand_found,
  input  logic [IDX_W-1:0] cand_idx,
  input  logic [N-1:0]     cand_upto,
  input  irqd_msg_t        cand_msg,
  input  logic             msg_ready,
  output logic [N-1:0]     scope,
  output logic             active,
  output logic             msg_valid,
  output logic [IDX_W-1:0] msg_pin,
  output irqd_msg_t        msg_q,
  output logic [N-1:0]     clr_edge
);

  logic         armed_q;
  logic         in_pass_q;
  logic [N-1:0] todo_q;
  logic         consume;
  logic         accept;

  assign active  = in_pass_q | armed_q;
  assign scope   = in_pass_q ? todo_q : '1;
  assign consume = !in_pass_q && armed_q && !msg_valid;
  assign accept  = msg_valid && msg_ready;

  always_comb begin
    clr_edge = '0;
    if (accept && !msg_q.level) clr_edge[msg_pin] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      in_pass_q <= 1'b0;
      todo_q    <= '0;
      msg_valid <= 1'b0;
      msg_pin   <= '0;
      msg_q     <= '0;
    end else begin
      armed_q <= (consume ? 1'b0 : armed_q) | trig;
      if (msg_valid) begin
        if (msg_ready) msg_valid <= 1'b0;
      end else if (active) begin
        if (cand_found) begin
          msg_valid <= 1'b1;
          msg_pin   <= cand_idx;
          msg_q     <= cand_msg;
          todo_q    <= scope & ~cand_upto;
          in_pass_q <= 1'b1;
        end else begin
          in_pass_q <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/irq_dispatch_top.sv
module irq_dispatch_top
  import irqd_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int PIN_W    = $clog2(NUM_PINS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PINS-1:0]         irq_in,
  input  logic [NUM_PINS*ENTRY_W-1:0] entry_flat,
  input  logic [NUM_PINS-1:0]         entry_wr,
  output logic                        msg_valid,
  input  logic                        msg_ready,
  output logic [PIN_W-1:0]            msg_pin,
  output logic [7:0]                  msg_dest,
  output logic                        msg_dest_mode,
  output logic [2:0]                  msg_dlv_mode,
  output logic [7:0]                  msg_vector,
  output logic                        msg_polarity,
  output logic                        msg_trigger
);

  irqd_msg_t           dec [NUM_PINS];
  logic [NUM_PINS-1:0] mask_vec;
  logic [NUM_PINS-1:0] level_cfg;
  logic [NUM_PINS-1:0] unused_res;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_dec
    logic [ENTRY_W-1:0] e;
    assign e            = entry_flat[i*ENTRY_W +: ENTRY_W];
    assign dec[i]       = decode_entry(e);
    assign mask_vec[i]  = e[16];
    assign level_cfg[i] = e[15];
    assign unused_res[i] = ^{e[55:17], e[14], e[12]};
  end

  logic [NUM_PINS-1:0] pend, rise, clr_edge, scope, cand_req, cand_upto;
  logic                active, cand_found, trig;
  logic [PIN_W-1:0]    cand_idx;
  irqd_msg_t           cand_msg, msg_q;

  assign trig = (|rise) | (|entry_wr);

  irqd_capture #(.N(NUM_PINS)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .level_cfg (level_cfg),
    .clr_edge  (clr_edge),
    .pend      (pend),
    .rise      (rise)
  );

  assign cand_req = active ? (scope & pend & ~mask_vec) : '0;

  irqd_pick #(.N(NUM_PINS), .IDX_W(PIN_W)) u_pick (
    .req   (cand_req),
    .found (cand_found),
    .idx   (cand_idx),
    .upto  (cand_upto)
  );

  assign cand_msg = dec[cand_idx];

  irqd_sequencer #(.N(NUM_PINS), .IDX_W(PIN_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig       (trig),
    .cand_found (cand_found),
    .cand_idx   (cand_idx),
    .cand_upto  (cand_upto),
    .cand_msg   (cand_msg),
    .msg_ready  (msg_ready),
    .scope      (scope),
    .active     (active),
    .msg_valid  (msg_valid),
    .msg_pin    (msg_pin),
    .msg_q      (msg_q),
    .clr_edge   (clr_edge)
  );

  assign msg_dest      = msg_q.dest;
  assign msg_dest_mode = msg_q.dest_mode;
  assign msg_dlv_mode  = msg_q.dlv;
  assign msg_vector    = msg_q.vector;
  assign msg_polarity  = msg_q.polarity;
  assign msg_trigger   = msg_q.level;

endmodule

// File: rtl/irqd_checker.sv
module irqd_checker #(
  parameter int N     = 24,
  parameter int IDX_W = $clog2(N)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [IDX_W-1:0] msg_pin,
  input logic [7:0]       msg_dest,
  input logic             msg_dest_mode,
  input logic [2:0]       msg_dlv_mode,
  input logic [7:0]       msg_vector,
  input logic             msg_polarity,
  input logic             msg_trigger,
  input logic [N-1:0]     mask_vec
);

  logic [N-1:0] past_mask;
  always_ff @(posedge clk) past_mask <= mask_vec;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable({msg_pin, msg_dest, msg_dest_mode,
      msg_dlv_mode, msg_vector, msg_polarity, msg_trigger}))); // R10

  AST_DROP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready) |=> !msg_valid); // R10

  AST_EXTINT_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_dlv_mode == 3'd7) |-> (msg_vector == 8'hFF)); // R9

  AST_NOT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> !past_mask[msg_pin]); // R6

  AST_PIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (int'(msg_pin) < N)); // R7

endmodule

bind irq_dispatch_top irqd_checker #(.N(NUM_PINS), .IDX_W(PIN_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .msg_valid     (msg_valid),
  .msg_ready     (msg_ready),
  .msg_pin       (msg_pin),
  .msg_dest      (msg_dest),
  .msg_dest_mode (msg_dest_mode),
  .msg_dlv_mode  (msg_dlv_mode),
  .msg_vector    (msg_vector),
  .msg_polarity  (msg_polarity),
  .msg_trigger   (msg_trigger),
  .mask_vec      (mask_vec)
);

// File: tb/tb_irq_dispatch_top.sv
module tb_irq_dispatch_top;

  localparam int NP = 24;
  localparam int PW = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NP-1:0]   irq_in = '0;
  logic [NP*64-1:0] entry_flat;
  logic [NP-1:0]   entry_wr = '0;
  logic            msg_valid, msg_ready = 1'b0;
  logic [PW-1:0]   msg_pin;
  logic [7:0]      msg_dest, msg_vector;
  logic            msg_dest_mode, msg_polarity, msg_trigger;
  logic [2:0]      msg_dlv_mode;
  logic [63:0]     ent [NP];

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  always_comb for (int i = 0; i < NP; i++) entry_flat[i*64 +: 64] = ent[i];

  irq_dispatch_top dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .entry_flat(entry_flat),
    .entry_wr(entry_wr), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_pin(msg_pin), .msg_dest(msg_dest), .msg_dest_mode(msg_dest_mode),
    .msg_dlv_mode(msg_dlv_mode), .msg_vector(msg_vector),
    .msg_polarity(msg_polarity), .msg_trigger(msg_trigger)
  );

  // row: pin[33:29] vec[28:21] dlv[20:18] dm[17] pol[16] dest[15:8] expected vector[7:0]
  localparam logic [33:0] TBL [6] = '{
    {5'd3,  8'h41, 3'd0, 1'b0, 1'b0, 8'h02, 8'h41},
    {5'd0,  8'h30, 3'd1, 1'b1, 1'b1, 8'hA5, 8'h30},
    {5'd23, 8'hFE, 3'd4, 1'b0, 1'b0, 8'hFF, 8'hFE},
    {5'd12, 8'h77, 3'd7, 1'b1, 1'b0, 8'h10, 8'hFF},
    {5'd7,  8'h10, 3'd2, 1'b0, 1'b1, 8'h00, 8'h10},
    {5'd19, 8'h9C, 3'd5, 1'b1, 1'b1, 8'h3C, 8'h9C}
  };

  function automatic logic [63:0] mk(input logic [7:0] vec, input logic [2:0] dlv,
      input logic dm, input logic pol, input logic lvl, input logic msk, input logic [7:0] dest);
    return {dest, 39'd0, msk, lvl, 1'b0, pol, 1'b0, dm, dlv, vec};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_entry(input int pin, input logic [63:0] val);
    ent[pin] = val;
    entry_wr = '0;
    entry_wr[pin] = 1'b1;
    @(negedge clk);
    entry_wr = '0;
  endtask

  task automatic expect_none(input int n, input string tag);
    bit seen = 1'b0;
    repeat (n) begin
      @(negedge clk);
      if (msg_valid) seen = 1'b1;
    end
    chk(!seen, tag, 64'(seen), 64'd0);
  endtask

  task automatic expect_msg(input int pin, input logic [7:0] vec, input logic [7:0] dest,
      input logic dm, input logic [2:0] dlv, input logic pol, input logic lvl, input string tag);
    logic [63:0] got, want;
    int n = 0;
    while (!msg_valid && n < 40) begin
      @(negedge clk);
      n++;
    end
    want = 64'({5'(pin), dest, dm, dlv, vec, pol, lvl});
    got  = 64'({msg_pin, msg_dest, msg_dest_mode, msg_dlv_mode, msg_vector, msg_polarity, msg_trigger});
    chk(msg_valid && got == want, tag, got, want);
    repeat (2) @(negedge clk);
    got = 64'({msg_pin, msg_dest, msg_dest_mode, msg_dlv_mode, msg_vector, msg_polarity, msg_trigger});
    chk(msg_valid && got == want, "R10 held under back-pressure", got, want);
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
    chk(!msg_valid, "R10 valid drops after accept", 64'(msg_valid), 64'd0);
  endtask

  initial begin
    #(20 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NP; i++) ent[i] = mk(8'h20, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    // R1: line held high through reset on an unmasked edge pin
    ent[8] = mk(8'h88, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h08);
    irq_in[8] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!msg_valid, "R1 no message right after reset", 64'(msg_valid), 64'd0);
    expect_msg(8, 8'h88, 8'h08, 1'b0, 3'd0, 1'b0, 1'b0, "R1 history cleared, held line seen as edge");
    irq_in[8] = 1'b0;
    set_entry(8, mk(8'h88, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h08));
    expect_none(6, "R1 no stray message");

    // table walk: R2 latency, R8 field decode, R9 forced vector, R3 clear
    for (int r = 0; r < 6; r++) begin
      logic [33:0] row;
      int pin;
      row = TBL[r];
      pin = int'(row[33:29]);
      set_entry(pin, mk(row[28:21], row[20:18], row[17], row[16], 1'b0, 1'b0, row[15:8]));
      irq_in[pin] = 1'b1;
      @(negedge clk);
      chk(!msg_valid, "R2 not yet valid one edge after rise", 64'(msg_valid), 64'd0);
      @(negedge clk);
      chk(msg_valid, "R2 valid two edges after rise", 64'(msg_valid), 64'd1);
      expect_msg(pin, row[7:0], row[15:8], row[17], row[20:18], row[16], 1'b0,
                 (row[20:18] == 3'd7) ? "R9 forced vector" : "R8 fields");
      irq_in[pin] = 1'b0;
      set_entry(pin, mk(row[28:21], row[20:18], row[17], row[16], 1'b0, 1'b0, row[15:8]));
      expect_none(6, "R3 edge request cleared on accept");
    end

    // R7: three pins rising together are sent lowest first
    set_entry(2,  mk(8'h52, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01));
    set_entry(9,  mk(8'h59, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01));
    set_entry(15, mk(8'h5F, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01));
    irq_in[15] = 1'b1; irq_in[9] = 1'b1; irq_in[2] = 1'b1;
    expect_msg(2,  8'h52, 8'h01, 1'b0, 3'd0, 1'b0, 1'b0, "R7 first pin 2");
    expect_msg(9,  8'h59, 8'h01, 1'b0, 3'd0, 1'b0, 1'b0, "R7 second pin 9");
    expect_msg(15, 8'h5F, 8'h01, 1'b0, 3'd0, 1'b0, 1'b0, "R7 third pin 15");
    irq_in[15] = 1'b0; irq_in[9] = 1'b0; irq_in[2] = 1'b0;
    expect_none(6, "R7 nothing after the pass");

    // R6 / R2: masked edge request survives line fall, delivered on unmask
    set_entry(4, mk(8'h60, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h05));
    irq_in[4] = 1'b1;
    @(negedge clk);
    irq_in[4] = 1'b0;
    expect_none(8, "R6 masked pin skipped");
    set_entry(4, mk(8'h60, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h05));
    expect_msg(4, 8'h60, 8'h05, 1'b0, 3'd0, 1'b0, 1'b0, "R6 pending kept, sent on unmask (R2 fall ignored)");
    set_entry(4, mk(8'h60, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h05));
    expect_none(6, "R3 cleared after unmask delivery");

    // R4 / R5 / R11: level pin behaviour
    set_entry(6, mk(8'h55, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h21));
    irq_in[6] = 1'b1;
    expect_msg(6, 8'h55, 8'h21, 1'b0, 3'd0, 1'b1, 1'b1, "R4 level delivered");
    expect_none(12, "R11 no resend without trigger");
    set_entry(6, mk(8'h55, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h21));
    expect_msg(6, 8'h55, 8'h21, 1'b0, 3'd0, 1'b1, 1'b1, "R4 level still pending on rewrite");
    irq_in[6] = 1'b0;
    repeat (2) @(negedge clk);
    set_entry(6, mk(8'h55, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h21));
    expect_none(8, "R5 level cleared by low line");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule